// File: doc/BRIEF.md
# Data-recovery loop filter with fine phase selection

This block is the digital loop behind a clock-and-data-recovery receiver. A phase detector outside it compares incoming serial transitions with a bank of evenly spaced clock phases and reports each comparison as an early or late strobe. The block integrates those strobes in a signed accumulator, which acts as a low-pass filter so that isolated jitter-driven decisions do not move the sampling point. Each time the accumulator reaches a positive or negative threshold, the phase selection moves by one fine interpolation step. The selection is presented as a coarse phase number and a fine sub-step.

The deserialized receive word passes through the block on a valid-only stream. A serial line cannot be stalled, so the receive side has no back-pressure: every accepted word appears on the output one cycle later, whether or not anything downstream is ready. An active-low hold input freezes the loop and the output word. While no valid data arrives, the loop ramps the phase forward on its own to search for a lock. A test mode drives the accumulator directly from increment and decrement pulses and shows its value on the receive word output.

Top module: `cdr_loop_filter`

## Requirements
- R1: When `rst_n` is low at a rising edge, the edge clears the accumulator, `coarse` and `fine` to 0, `rx_valid` to 0 and `rx_data` to 0, whatever the other inputs are.
- R2: In normal mode (`hold_n`=1, `tst_en`=0, `din_vld`=1), a `late` strobe adds 1 to the accumulator and an `early` strobe subtracts 1. Both strobes together, or neither, leave it unchanged.
- R3: When the updated sum would reach +THR (default 16), the accumulator takes the sum minus THR and the phase advances one fine step. When the sum would reach -THR, it takes the sum plus THR and the phase retreats one fine step. The accumulator stays strictly between -THR and +THR.
- R4: `fine` counts 0..7 inside each `coarse` phase 0..4, giving 40 positions. Advancing from coarse 4, fine 7 gives coarse 0, fine 0. Retreating from coarse 0, fine 0 gives coarse 4, fine 7.
- R5: In normal mode with `din_vld`=0, the accumulator gains 1 every cycle and the strobes are ignored, so the phase ramps forward by one fine step every THR cycles.
- R6: While `hold_n`=0, the accumulator, `coarse`, `fine` and `rx_data` keep their values, and `rx_valid` is 0 the next cycle. Strobes, test pulses and data are ignored.
- R7: With `tst_en`=1 and `hold_n`=1, `tst_inc` adds 1 and `tst_dec` subtracts 1, and both together cancel. The strobes and `din_vld` are ignored, and the threshold rule of R3 still applies. After each such edge, `rx_data` holds the updated accumulator as a 10-bit two's-complement value and `rx_valid` is 1.
- R8: In normal mode, `rx_valid` follows `din_vld` one cycle later. A word with `din_vld`=1 appears on `rx_data` the following cycle, and `rx_data` holds its value while `din_vld`=0.
- R9: A phase step appears on `coarse` and `fine` after the same edge that applies the threshold subtraction to the accumulator, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered-word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hold_n | input | 1 | Loop and output freeze, active low |
| din | input | 10 | Deserialized receive word |
| din_vld | input | 1 | `din` carries a valid word; low means no usable data |
| early | input | 1 | Phase detector: sampling clock is early |
| late | input | 1 | Phase detector: sampling clock is late |
| tst_en | input | 1 | Test mode: accumulator driven by pulses |
| tst_inc | input | 1 | Test increment pulse |
| tst_dec | input | 1 | Test decrement pulse |
| rx_data | output | 10 | Receive word, or accumulator value in test mode |
| rx_valid | output | 1 | `rx_data` updated this cycle |
| coarse | output | 3 | Selected coarse clock phase (0..4) |
| fine | output | 3 | Interpolation sub-step (0..7) |

## Verification
The hardest state to reach from the ports is the negative half of the loop: the accumulator below zero and the backward wrap from coarse 0, fine 0 to coarse 4, fine 7. The free-running ramp only ever moves the phase forward. The bench reaches the negative range in two ways. It applies decrement pulses in test mode, where the negative accumulator value is visible on `rx_data` after every edge. It also sends runs of early strobes with valid data, long enough to cross the lower threshold several times and to wrap below zero. A full forward ramp of more than 40 steps then checks the opposite wrap, with early strobes held active throughout to show that they are ignored.

// File: rtl/cdr_lf_pkg.sv
package cdr_lf_pkg;

  // Where the accumulator increment comes from in a given cycle
  typedef enum logic [1:0] {
    SRC_DETECTOR = 2'd0,
    SRC_RAMP     = 2'd1,
    SRC_TEST     = 2'd2
  } lf_src_e;

  // One step of the phase selection requested by the filter
  typedef struct packed {
    logic up;
    logic dn;
  } lf_step_t;

endpackage

// File: rtl/lf_delta_sel.sv
module lf_delta_sel
  import cdr_lf_pkg::*;
(
  input  logic              tst_en,
  input  logic              tst_inc,
  input  logic              tst_dec,
  input  logic              din_vld,
  input  logic              early,
  input  logic              late,
  output logic signed [1:0] delta
);

  lf_src_e src;

  always_comb begin
    if (tst_en)       src = SRC_TEST;
    else if (!din_vld) src = SRC_RAMP;
    else              src = SRC_DETECTOR;
  end

  always_comb begin
    unique case (src)
      SRC_TEST:     delta = $signed({1'b0, tst_inc}) - $signed({1'b0, tst_dec});
      SRC_RAMP:     delta = 2'sd1;
      SRC_DETECTOR: delta = $signed({1'b0, late}) - $signed({1'b0, early});
      default:      delta = 2'sd0;
    endcase
  end

endmodule

// File: rtl/lf_accum.sv
module lf_accum
  import cdr_lf_pkg::*;
#(
  parameter int ACC_W = 10,
  parameter int THR   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [1:0]       delta,
  output logic signed [ACC_W-1:0] acc_q,
  output logic signed [ACC_W-1:0] acc_nxt,
  output lf_step_t                step
);

  localparam int SUM_W = ACC_W + 1;
  localparam logic signed [SUM_W-1:0] THR_S = SUM_W'(THR);

  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum     = {acc_q[ACC_W-1], acc_q} + {{(SUM_W-2){delta[1]}}, delta};
    step.up = (sum >= THR_S);
    step.dn = (sum <= -THR_S);
    if (step.up)      acc_nxt = ACC_W'(sum - THR_S);
    else if (step.dn) acc_nxt = ACC_W'(sum + THR_S);
    else              acc_nxt = ACC_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_nxt;
  end

endmodule

// File: rtl/lf_phase_ctr.sv
module lf_phase_ctr
  import cdr_lf_pkg::*;
#(
  parameter int N_COARSE = 5,
  parameter int N_FINE   = 8,
  localparam int CW = $clog2(N_COARSE),
  localparam int FW = $clog2(N_FINE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  lf_step_t      step,
  output logic [CW-1:0] coarse,
  output logic [FW-1:0] fine
);

  localparam logic [CW-1:0] CMAX = CW'(N_COARSE - 1);
  localparam logic [FW-1:0] FMAX = FW'(N_FINE - 1);

  logic [FW-1:0] fine_inc, fine_dec;
  logic          fine_top, fine_bot;

  assign fine_top = (fine == FMAX);
  assign fine_bot = (fine == '0);

  generate
    if ((1 << FW) == N_FINE) begin : g_pow2
      assign fine_inc = fine + 1'b1;
      assign fine_dec = fine - 1'b1;
    end else begin : g_mod
      assign fine_inc = fine_top ? '0 : fine + 1'b1;
      assign fine_dec = fine_bot ? FMAX : fine - 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarse <= '0;
      fine   <= '0;
    end else if (en) begin
      if (step.up) begin
        fine <= fine_inc;
        if (fine_top) coarse <= (coarse == CMAX) ? '0 : coarse + 1'b1;
      end else if (step.dn) begin
        fine <= fine_dec;
        if (fine_bot) coarse <= (coarse == '0) ? CMAX : coarse - 1'b1;
      end
    end
  end

endmodule

// File: rtl/lf_rx_out.sv
module lf_rx_out #(
  parameter int DATA_W = 10,
  parameter int ACC_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hold_n,
  input  logic                    tst_en,
  input  logic signed [ACC_W-1:0] acc_nxt,
  input  logic [DATA_W-1:0]       din,
  input  logic                    din_vld,
  output logic [DATA_W-1:0]       rx_data,
  output logic                    rx_valid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (!hold_n) begin
      rx_valid <= 1'b0;
    end else if (tst_en) begin
      rx_data  <= DATA_W'(acc_nxt);
      rx_valid <= 1'b1;
    end else begin
      rx_valid <= din_vld;
      if (din_vld) rx_data <= din;
    end
  end

endmodule

// File: rtl/cdr_loop_filter.sv
module cdr_loop_filter
  import cdr_lf_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int ACC_W    = 10,
  parameter int THR      = 16,
  parameter int N_COARSE = 5,
  parameter int N_FINE   = 8,
  localparam int CW = $clog2(N_COARSE),
  localparam int FW = $clog2(N_FINE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_n,
  input  logic [DATA_W-1:0] din,
  input  logic              din_vld,
  input  logic              early,
  input  logic              late,
  input  logic              tst_en,
  input  logic              tst_inc,
  input  logic              tst_dec,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic [CW-1:0]     coarse,
  output logic [FW-1:0]     fine
);

  logic signed [1:0]       delta;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_nxt;
  lf_step_t                step;
  logic                    stp_up, stp_dn;

  assign stp_up = step.up;
  assign stp_dn = step.dn;

  lf_delta_sel u_sel (
    .tst_en (tst_en),
    .tst_inc(tst_inc),
    .tst_dec(tst_dec),
    .din_vld(din_vld),
    .early  (early),
    .late   (late),
    .delta  (delta)
  );

  lf_accum #(.ACC_W(ACC_W), .THR(THR)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (hold_n),
    .delta  (delta),
    .acc_q  (acc_q),
    .acc_nxt(acc_nxt),
    .step   (step)
  );

  lf_phase_ctr #(.N_COARSE(N_COARSE), .N_FINE(N_FINE)) u_ph (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (hold_n),
    .step  (step),
    .coarse(coarse),
    .fine  (fine)
  );

  lf_rx_out #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_n  (hold_n),
    .tst_en  (tst_en),
    .acc_nxt (acc_nxt),
    .din     (din),
    .din_vld (din_vld),
    .rx_data (rx_data),
    .rx_valid(rx_valid)
  );

endmodule

// File: rtl/cdr_loop_filter_chk.sv
module cdr_loop_filter_chk #(
  parameter int DATA_W   = 10,
  parameter int ACC_W    = 10,
  parameter int THR      = 16,
  parameter int N_COARSE = 5,
  parameter int N_FINE   = 8,
  localparam int CW = $clog2(N_COARSE),
  localparam int FW = $clog2(N_FINE)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    hold_n,
  input logic                    din_vld,
  input logic                    early,
  input logic                    late,
  input logic                    tst_en,
  input logic                    tst_inc,
  input logic                    tst_dec,
  input logic [DATA_W-1:0]       rx_data,
  input logic                    rx_valid,
  input logic [CW-1:0]           coarse,
  input logic [FW-1:0]           fine,
  input logic signed [ACC_W-1:0] acc_q,
  input logic                    stp_up,
  input logic                    stp_dn
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (acc_q == '0 && coarse == '0 && fine == '0 && !rx_valid && rx_data == '0));

  // R2
  strobe_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_n && !tst_en && din_vld && early && late) |=> $stable(acc_q));

  // R3
  acc_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(acc_q) < THR) && ($signed(acc_q) > -THR));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stp_up && stp_dn));

  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(coarse) < N_COARSE) && (int'(fine) < N_FINE));

  // R5
  ramp_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_n && !tst_en && !din_vld && ($signed(acc_q) < THR - 1))
      |=> ($signed(acc_q) == $signed($past(acc_q)) + 1));

  // R6
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> ($stable(acc_q) && $stable(coarse) && $stable(fine) &&
                 $stable(rx_data) && !rx_valid));

  // R7
  test_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_n && tst_en && tst_inc && tst_dec) |=> ($stable(acc_q) && rx_valid));

  // R9
  step_phase_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_n && (stp_up || stp_dn)) |=> !($stable(fine)));

endmodule

bind cdr_loop_filter cdr_loop_filter_chk #(
  .DATA_W(DATA_W), .ACC_W(ACC_W), .THR(THR), .N_COARSE(N_COARSE), .N_FINE(N_FINE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hold_n  (hold_n),
  .din_vld (din_vld),
  .early   (early),
  .late    (late),
  .tst_en  (tst_en),
  .tst_inc (tst_inc),
  .tst_dec (tst_dec),
  .rx_data (rx_data),
  .rx_valid(rx_valid),
  .coarse  (coarse),
  .fine    (fine),
  .acc_q   (acc_q),
  .stp_up  (stp_up),
  .stp_dn  (stp_dn)
);

// File: tb/cdr_loop_filter_bench.sv
`timescale 1ns/1ps
module cdr_loop_filter_bench;
  localparam int THR = 16;
  localparam int NC  = 5;
  localparam int NF  = 8;
  localparam int NPH = NC * NF;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0, hold_n = 1'b1, tst_en = 1'b0, tst_inc = 1'b0, tst_dec = 1'b0;
  logic       din_vld = 1'b0, early = 1'b0, late = 1'b0;
  logic [9:0] din = '0;
  logic [9:0] rx_data;
  logic       rx_valid;
  logic [2:0] coarse, fine;

  cdr_loop_filter u_cdr_loop_filter (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .din(din), .din_vld(din_vld),
    .early(early), .late(late), .tst_en(tst_en), .tst_inc(tst_inc), .tst_dec(tst_dec),
    .rx_data(rx_data), .rx_valid(rx_valid), .coarse(coarse), .fine(fine)
  );

  int m_acc = 0, m_idx = 0, m_rxd = 0, m_rxv = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Behavioural reference: one call is one clock of stimulus and one comparison.
  task automatic cyc(input bit r, input bit h, input bit te, input bit ti, input bit td,
                     input bit dv, input bit e, input bit l, input logic [9:0] d,
                     input string tag);
    int dl, s;
    rst_n = r; hold_n = h; tst_en = te; tst_inc = ti; tst_dec = td;
    din_vld = dv; early = e; late = l; din = d;
    if (!r) begin
      m_acc = 0; m_idx = 0; m_rxd = 0; m_rxv = 0;
    end else if (!h) begin
      m_rxv = 0;
    end else begin
      if (te)       dl = int'(ti) - int'(td);
      else if (!dv) dl = 1;
      else          dl = int'(l) - int'(e);
      s = m_acc + dl;
      if (s >= THR)       begin s -= THR; m_idx = (m_idx + 1) % NPH; end
      else if (s <= -THR) begin s += THR; m_idx = (m_idx + NPH - 1) % NPH; end
      m_acc = s;
      if (te) begin m_rxd = s & 10'h3FF; m_rxv = 1; end
      else begin
        m_rxv = dv;
        if (dv) m_rxd = int'(d);
      end
    end
    @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (int'(coarse) != m_idx / NF || int'(fine) != m_idx % NF ||
        int'(rx_valid) != m_rxv || int'(rx_data) != m_rxd) begin
      n_bad++;
      $display("FAIL %s: coarse=%0d fine=%0d vld=%0d data=%h expected coarse=%0d fine=%0d vld=%0d data=%h",
               tag, coarse, fine, rx_valid, rx_data, m_idx / NF, m_idx % NF, m_rxv, m_rxd[9:0]);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset dominates every other input
    repeat (3) cyc(0, 1, 1, 1, 0, 1, 1, 0, 10'h2AA, "R1");
    // R8: data passes with one cycle of latency, no strobes
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 0, 1, 0, 0, 10'h100 + 10'(i), "R8");
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 10'h3FF, "R8");
    cyc(1, 1, 0, 0, 0, 1, 0, 0, 10'h0F0, "R8");
    // R2: late, early, both, neither
    repeat (10) cyc(1, 1, 0, 0, 0, 1, 0, 1, 10'h155, "R2");
    repeat (4)  cyc(1, 1, 0, 0, 0, 1, 1, 0, 10'h0AA, "R2");
    repeat (5)  cyc(1, 1, 0, 0, 0, 1, 1, 1, 10'h033, "R2");
    repeat (3)  cyc(1, 1, 0, 0, 0, 1, 0, 0, 10'h1CC, "R2");
    // R7: accumulator readback, decrements into negative, both cancel
    cyc(1, 1, 1, 0, 0, 0, 0, 0, 10'h000, "R7");
    repeat (20) cyc(1, 1, 1, 0, 1, 0, 0, 1, 10'h3A5, "R7");
    repeat (4)  cyc(1, 1, 1, 1, 1, 1, 1, 0, 10'h111, "R7");
    // R4: cross -THR from position 0, wrapping backward to the last position
    repeat (3) cyc(1, 1, 1, 0, 1, 0, 0, 0, 10'h000, "R4");
    // R6: hold freezes everything despite strobes, pulses and data
    repeat (4) cyc(1, 0, 1, 1, 0, 1, 0, 1, 10'h2F0, "R6");
    repeat (4) cyc(1, 0, 0, 0, 0, 0, 1, 0, 10'h0F2, "R6");
    // R5: ramp with no data, early strobes ignored; wraps forward past 40 steps
    repeat (NPH * THR + 40) cyc(1, 1, 0, 0, 0, 0, 1, 0, 10'h000, "R5");
    // R3: early strobes with data, crossing -THR repeatedly
    for (int i = 0; i < THR * 9; i++) cyc(1, 1, 0, 0, 0, 1, 1, 0, 10'(i), "R3");
    // R9: test increments crossing +THR, step visible after the same edge
    repeat (2 * THR + 3) cyc(1, 1, 1, 1, 0, 0, 0, 0, 10'h000, "R9");
    // R1: reset in mid-run
    cyc(0, 1, 0, 0, 0, 1, 0, 1, 10'h155, "R1");
    repeat (3) cyc(1, 1, 0, 0, 0, 1, 0, 1, 10'h2AB, "R2");
    cyc(1, 1, 1, 0, 0, 0, 0, 0, 10'h000, "R7");
    done = 1'b1;
    summary();
    $finish;
  end

endmodule